// File: doc/BRIEF.md
# Reference Clock Switchover Controller

This block supervises two redundant reference clocks against a feedback clock. All of them, together with the control inputs, are oversampled in a fast system clock domain. Each reference has its own loss monitor. The monitor counts rising edges of the feedback clock. It raises a sticky bad flag when a set number of feedback edges pass without a rising edge of that reference. Both references are watched all the time, so the idle one is monitored as well as the active one.

A selection state machine has three states: `ST_WARM`, `ST_REF0` and `ST_REF1`.

- **After master reset:** the machine stays in `ST_WARM` until the synchronizers have filled. It then takes transition *warm-to-user*, which loads the user select.
- **Automatic mode:** if the active reference goes bad and the other one is still clean, the machine takes transition *auto-switch* to the other state.
- **Holding:** otherwise the machine stays where it is (*hold*). This covers the case where both references are bad.
- **Manual override:** when override is high, transition *override-follow* makes the state track the user select on every cycle, and automatic switching is off.
- **Alarm reset:** an active-low alarm reset clears both flags and takes transition *alarm-realign*, which returns the state to the user select.

Downstream logic receives a one-line selection indicator and a one-hot mux select.

Top module: `ref_switch_ctrl`

## Requirements
- R1: While `rst_n` is low, both bad flags are low. After `rst_n` rises with the user select held steady, the selection equals the user select within 4 system clocks.
- R2: `sel_ind` is low when reference 0 is active and high when reference 1 is active. `mux_sel` is one-hot: bit 0 selects reference 0 and bit 1 selects reference 1, so bit 1 always equals `sel_ind`.
- R3: A reference's bad flag sets once the feedback clock has produced LOSS_EDGES rising edges (default 4) with no rising edge of that reference among them. A reference rising edge restarts the count. Fewer than LOSS_EDGES feedback edges leave the flag clear.
- R4: A bad flag stays high, even after its reference resumes toggling, until the alarm reset is applied.
- R5: While `alarm_clr_n` is low (after synchronization), both bad flags are cleared and the selection is set equal to the user select.
- R6: While `man_ovr` is high, the selection follows the user select and no automatic switch occurs, even when the active reference is bad. The bad flags are still set by the monitors.
- R7: In automatic mode, when the active reference's flag is set and the other flag is clear, the selection moves to the other reference on the system clock after the flag rises.
- R8: In automatic mode, with both flags set, the selection keeps its current value.
- R9: The inactive reference is still monitored, and its flag can set without changing the selection.
- R10: In automatic mode with no flag set and no alarm reset, changes on `user_sel` do not alter the selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sys | input | 1 | Fast system clock that samples all inputs |
| rst_n | input | 1 | Asynchronous active-low master reset |
| ref0_clk | input | 1 | Reference clock 0 |
| ref1_clk | input | 1 | Reference clock 1 |
| fb_clk | input | 1 | Feedback clock |
| user_sel | input | 1 | User reference choice, 0 = reference 0, 1 = reference 1 |
| man_ovr | input | 1 | High disables automatic switching |
| alarm_clr_n | input | 1 | Active-low alarm reset |
| sel_ind | output | 1 | Active reference indicator |
| ref0_bad | output | 1 | Sticky bad flag of reference 0 |
| ref1_bad | output | 1 | Sticky bad flag of reference 1 |
| mux_sel | output | 2 | One-hot select for a downstream clock mux |

## Verification
The bench drives exact numbers of feedback pulses to probe the loss threshold. A design that counted one edge too few or too many, or that failed to restart the count on a reference edge, would raise the flag at the wrong pulse. It restarts a stopped reference to confirm that the flag does not self-clear and that the selection does not drift back to the original reference. It also checks that the switch lands exactly one clock after the flag rises. With both references failed, and with override high while the active reference dies, it confirms the selection holds, where a careless design would toggle between the references or switch anyway. Toggling the user select in automatic mode must have no effect until an alarm reset realigns the selection.

// File: rtl/ref_switch_pkg.sv
package ref_switch_pkg;

    typedef enum logic [1:0] {
        ST_WARM = 2'd0,
        ST_REF0 = 2'd1,
        ST_REF1 = 2'd2
    } sel_state_t;

    // bit positions inside the synchronized input vector
    localparam int unsigned IDX_REF0  = 0;
    localparam int unsigned IDX_REF1  = 1;
    localparam int unsigned IDX_FB    = 2;
    localparam int unsigned IDX_USER  = 3;
    localparam int unsigned IDX_MAN   = 4;
    localparam int unsigned IDX_ALARM = 5;
    localparam int unsigned NUM_IN    = 6;
    localparam int unsigned NUM_CLK   = 3;

    function automatic sel_state_t state_of(input logic pick_one);
        return pick_one ? ST_REF1 : ST_REF0;
    endfunction

endpackage

// File: rtl/rs_sync.sv
module rs_sync #(
    parameter int unsigned       WIDTH   = 1,
    parameter int unsigned       STAGES  = 2,
    parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [STAGES-1:0][WIDTH-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= RST_VAL;
        else        chain[0] <= d;
    end

    generate
        for (genvar g = 1; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[g] <= RST_VAL;
                else        chain[g] <= chain[g-1];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/rs_rise.sv
module rs_rise #(
    parameter int unsigned WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] lvl,
    output logic [WIDTH-1:0] rise
);

    logic [WIDTH-1:0] prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= '0;
        else        prev <= lvl;
    end

    generate
        for (genvar g = 0; g < WIDTH; g++) begin : g_bit
            assign rise[g] = lvl[g] & ~prev[g];
        end
    endgenerate

endmodule

// File: rtl/rs_loss_mon.sv
module rs_loss_mon #(
    parameter int unsigned LOSS_EDGES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic ref_rise,
    input  logic fb_rise,
    output logic bad
);

    localparam int unsigned CW   = (LOSS_EDGES > 2) ? $clog2(LOSS_EDGES) : 1;
    localparam logic [CW-1:0] LAST = CW'(LOSS_EDGES - 1);

    logic [CW-1:0] cnt;
    logic          flag;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            flag <= 1'b0;
        end else if (clr) begin
            cnt  <= '0;
            flag <= 1'b0;
        end else if (ref_rise) begin
            cnt  <= '0;
        end else if (fb_rise) begin
            if (cnt == LAST) flag <= 1'b1;
            else             cnt  <= cnt + 1'b1;
        end
    end

    assign bad = flag;

endmodule

// File: rtl/rs_sel_fsm.sv
module rs_sel_fsm
    import ref_switch_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       user_s,
    input  logic       man_s,
    input  logic       alarm_s,
    input  logic       bad0,
    input  logic       bad1,
    output logic       sel_ind,
    output logic [1:0] mux_sel,
    output logic       warm
);

    localparam int unsigned WW = $clog2(SYNC_STAGES + 1);
    localparam logic [WW-1:0] WARM_END = WW'(SYNC_STAGES);

    sel_state_t    state_q, state_d;
    logic [WW-1:0] warm_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 warm_cnt <= '0;
        else if (state_q == ST_WARM) warm_cnt <= warm_cnt + 1'b1;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WARM: begin
                if (warm_cnt == WARM_END) state_d = state_of(user_s); // warm-to-user
            end
            ST_REF0: begin
                if (man_s || alarm_s)  state_d = state_of(user_s);    // override-follow / alarm-realign
                else if (bad0 && !bad1) state_d = ST_REF1;            // auto-switch
            end
            ST_REF1: begin
                if (man_s || alarm_s)  state_d = state_of(user_s);
                else if (bad1 && !bad0) state_d = ST_REF0;
            end
            default: state_d = ST_WARM;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_WARM;
        else        state_q <= state_d;
    end

    always_comb begin
        warm    = 1'b0;
        sel_ind = 1'b0;
        unique case (state_q)
            ST_WARM: begin
                warm    = 1'b1;
                sel_ind = user_s;
            end
            ST_REF0: sel_ind = 1'b0;
            ST_REF1: sel_ind = 1'b1;
            default: sel_ind = 1'b0;
        endcase
        mux_sel = {sel_ind, ~sel_ind};
    end

endmodule

// File: rtl/ref_switch_ctrl.sv
module ref_switch_ctrl
    import ref_switch_pkg::*;
#(
    parameter int unsigned LOSS_EDGES  = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk_sys,
    input  logic       rst_n,
    input  logic       ref0_clk,
    input  logic       ref1_clk,
    input  logic       fb_clk,
    input  logic       user_sel,
    input  logic       man_ovr,
    input  logic       alarm_clr_n,
    output logic       sel_ind,
    output logic       ref0_bad,
    output logic       ref1_bad,
    output logic [1:0] mux_sel
);

    localparam logic [NUM_IN-1:0] SYNC_RST = NUM_IN'(1) << IDX_ALARM;

    logic [NUM_IN-1:0]  raw_in, syn_in;
    logic [NUM_CLK-1:0] clk_rise;
    logic               user_s, man_s, alarm_s, warm;
    logic [1:0]         bad;

    always_comb begin
        raw_in            = '0;
        raw_in[IDX_REF0]  = ref0_clk;
        raw_in[IDX_REF1]  = ref1_clk;
        raw_in[IDX_FB]    = fb_clk;
        raw_in[IDX_USER]  = user_sel;
        raw_in[IDX_MAN]   = man_ovr;
        raw_in[IDX_ALARM] = alarm_clr_n;
    end

    rs_sync #(.WIDTH(NUM_IN), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
        .clk(clk_sys), .rst_n(rst_n), .d(raw_in), .q(syn_in)
    );

    rs_rise #(.WIDTH(NUM_CLK)) u_rise (
        .clk(clk_sys), .rst_n(rst_n), .lvl(syn_in[NUM_CLK-1:0]), .rise(clk_rise)
    );

    assign user_s  = syn_in[IDX_USER];
    assign man_s   = syn_in[IDX_MAN];
    assign alarm_s = ~syn_in[IDX_ALARM];

    generate
        for (genvar g = 0; g < 2; g++) begin : g_mon
            rs_loss_mon #(.LOSS_EDGES(LOSS_EDGES)) u_mon (
                .clk(clk_sys), .rst_n(rst_n), .clr(alarm_s),
                .ref_rise(clk_rise[g]), .fb_rise(clk_rise[IDX_FB]), .bad(bad[g])
            );
        end
    endgenerate

    rs_sel_fsm #(.SYNC_STAGES(SYNC_STAGES)) u_fsm (
        .clk(clk_sys), .rst_n(rst_n), .user_s(user_s), .man_s(man_s),
        .alarm_s(alarm_s), .bad0(bad[0]), .bad1(bad[1]),
        .sel_ind(sel_ind), .mux_sel(mux_sel), .warm(warm)
    );

    assign ref0_bad = bad[0];
    assign ref1_bad = bad[1];

endmodule

// File: rtl/ref_switch_ctrl_chk.sv
module ref_switch_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       user_s,
    input logic       man_s,
    input logic       alarm_s,
    input logic       warm,
    input logic       bad0,
    input logic       bad1,
    input logic       sel_ind,
    input logic [1:0] mux_sel
);

    p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(mux_sel) && (mux_sel[1] == sel_ind));

    p_sticky0_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bad0 && !alarm_s) |=> bad0);

    p_sticky1_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bad1 && !alarm_s) |=> bad1);

    p_alarm_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_s |=> (!bad0 && !bad1));

    p_alarm_align_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_s && !warm) |=> (sel_ind == $past(user_s)));

    p_override_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (man_s && !warm) |=> (sel_ind == $past(user_s)));

    p_switch_up_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!warm && !man_s && !alarm_s && !sel_ind && bad0 && !bad1) |=> sel_ind);

    p_switch_down_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!warm && !man_s && !alarm_s && sel_ind && bad1 && !bad0) |=> !sel_ind);

    p_both_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!warm && !man_s && !alarm_s && bad0 && bad1) |=> $stable(sel_ind));

    p_user_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!warm && !man_s && !alarm_s && !bad0 && !bad1) |=> $stable(sel_ind));

endmodule

bind ref_switch_ctrl ref_switch_ctrl_chk u_chk (
    .clk(clk_sys), .rst_n(rst_n), .user_s(user_s), .man_s(man_s),
    .alarm_s(alarm_s), .warm(warm), .bad0(bad[0]), .bad1(bad[1]),
    .sel_ind(sel_ind), .mux_sel(mux_sel)
);

// File: tb/test_ref_switch_ctrl.sv
module test_ref_switch_ctrl;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst_n, user_sel, man_ovr, alarm_clr_n;
    logic       sel_ind, ref0_bad, ref1_bad;
    logic [1:0] mux_sel;
    logic       run, en0, en1;
    logic       g_ref0, g_ref1, g_fb, m_ref0, m_ref1, m_fb;
    logic       ref0_clk, ref1_clk, fb_clk;
    int         checks = 0, errors = 0;
    logic       done = 1'b0;
    int         ph = 0;

    assign ref0_clk = run ? g_ref0 : m_ref0;
    assign ref1_clk = run ? g_ref1 : m_ref1;
    assign fb_clk   = run ? g_fb   : m_fb;

    ref_switch_ctrl i_ref_switch_ctrl (
        .clk_sys(clk), .rst_n(rst_n), .ref0_clk(ref0_clk), .ref1_clk(ref1_clk),
        .fb_clk(fb_clk), .user_sel(user_sel), .man_ovr(man_ovr),
        .alarm_clr_n(alarm_clr_n), .sel_ind(sel_ind), .ref0_bad(ref0_bad),
        .ref1_bad(ref1_bad), .mux_sel(mux_sel)
    );

    // free-running clock generator: every level lasts 4 system clocks
    initial begin g_ref0 = 0; g_ref1 = 0; g_fb = 0; end
    always @(negedge clk) begin
        if (run) begin
            ph = ph + 1;
            if (ph == 4) begin
                ph = 0;
                g_fb = ~g_fb;
                if (en0) g_ref0 = ~g_ref0;
                if (en1) g_ref1 = ~g_ref1;
            end
        end
    end

    // {man, user, alarm pulse, expected sel}
    localparam logic [3:0] VEC [0:6] = '{4'b0100, 4'b0111, 4'b0001, 4'b1000,
                                         4'b1101, 4'b0001, 4'b0010};

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic alarm_pulse();
        alarm_clr_n = 1'b0; cyc(3); alarm_clr_n = 1'b1; cyc(8);
    endtask

    task automatic pulse_fb();
        m_fb = 1'b1; cyc(3); m_fb = 1'b0; cyc(3);
    endtask

    task automatic wait_flag(input int which, output logic seen);
        seen = 1'b0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if ((which == 0 && ref0_bad) || (which == 1 && ref1_bad)) begin
                seen = 1'b1;
                break;
            end
        end
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R3 watchdog actual %0d expected %0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic seen;
        rst_n = 0; user_sel = 0; man_ovr = 0; alarm_clr_n = 1;
        run = 0; en0 = 1; en1 = 1; m_ref0 = 0; m_ref1 = 0; m_fb = 0;
        cyc(4);
        chk(!ref0_bad && !ref1_bad, "R1 flags in reset", {ref0_bad, ref1_bad}, 0);
        rst_n = 1;
        cyc(6);
        chk(sel_ind == 1'b0, "R1 sel after reset", sel_ind, 0);
        chk(mux_sel == 2'b01, "R2 mux after reset", mux_sel, 1);
        run = 1;
        cyc(40);

        for (int v = 0; v < 7; v++) begin
            man_ovr = VEC[v][3];
            user_sel = VEC[v][2];
            cyc(2);
            if (VEC[v][1]) alarm_pulse();
            cyc(8);
            chk(sel_ind == VEC[v][0], "R5/R6/R10 table sel", sel_ind, VEC[v][0]);
            chk(mux_sel == (VEC[v][0] ? 2'b10 : 2'b01), "R2 table mux", mux_sel,
                VEC[v][0] ? 2 : 1);
        end

        // active reference 0 dies
        en0 = 0;
        wait_flag(0, seen);
        chk(seen, "R3 ref0 loss flagged", seen, 1);
        chk(sel_ind == 1'b0, "R7 no switch before flag seen", sel_ind, 0);
        cyc(1);
        chk(sel_ind == 1'b1, "R7 switch one clock after flag", sel_ind, 1);
        chk(mux_sel == 2'b10, "R2 mux after switch", mux_sel, 2);
        chk(!ref1_bad, "R9 ref1 stays good", ref1_bad, 0);

        en0 = 1;
        cyc(60);
        chk(ref0_bad, "R4 flag sticky after resume", ref0_bad, 1);
        chk(sel_ind == 1'b1, "R4 no return to ref0", sel_ind, 1);

        en1 = 0;
        wait_flag(1, seen);
        chk(seen, "R3 ref1 loss flagged", seen, 1);
        cyc(4);
        chk(sel_ind == 1'b1, "R8 both bad holds", sel_ind, 1);

        en1 = 1; user_sel = 0;
        cyc(20);
        alarm_pulse();
        chk(!ref0_bad && !ref1_bad, "R5 flags cleared", {ref0_bad, ref1_bad}, 0);
        chk(sel_ind == 1'b0, "R5 realigned to user", sel_ind, 0);

        // idle reference monitored
        en1 = 0;
        wait_flag(1, seen);
        chk(seen, "R9 idle ref1 flagged", seen, 1);
        cyc(4);
        chk(sel_ind == 1'b0 && !ref0_bad, "R9 selection unchanged", sel_ind, 0);
        en1 = 1;
        cyc(20);
        alarm_pulse();

        // override blocks switching
        man_ovr = 1; user_sel = 0;
        cyc(4);
        en0 = 0;
        wait_flag(0, seen);
        chk(seen, "R6 flag still set under override", seen, 1);
        cyc(5);
        chk(sel_ind == 1'b0, "R6 no auto switch", sel_ind, 0);
        en0 = 1;
        cyc(20);
        alarm_pulse();
        man_ovr = 0;
        cyc(8);
        chk(sel_ind == 1'b0 && !ref0_bad, "R6 clean exit", sel_ind, 0);

        // exact threshold with hand-made pulses
        run = 0;
        cyc(4);
        alarm_pulse();
        for (int i = 0; i < 3; i++) pulse_fb();
        cyc(6);
        chk(!ref0_bad && !ref1_bad, "R3 three edges not enough", {ref0_bad, ref1_bad}, 0);
        pulse_fb();
        cyc(6);
        chk(ref0_bad && ref1_bad, "R3 fourth edge flags", {ref0_bad, ref1_bad}, 3);
        chk(sel_ind == 1'b0, "R8 both bad hold at ref0", sel_ind, 0);

        alarm_pulse();
        for (int i = 0; i < 3; i++) pulse_fb();
        m_ref0 = 1; cyc(3); m_ref0 = 0; cyc(3);
        for (int i = 0; i < 3; i++) pulse_fb();
        cyc(6);
        chk(!ref0_bad, "R3 ref edge restarts count", ref0_bad, 0);
        chk(ref1_bad, "R3 ref1 counted through", ref1_bad, 1);
        chk(sel_ind == 1'b0, "R7 idle bad does not move sel", sel_ind, 0);
        pulse_fb();
        cyc(6);
        chk(ref0_bad, "R3 flag after restart window", ref0_bad, 1);
        chk(sel_ind == 1'b0, "R8 hold with both bad", sel_ind, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule